// File: doc/BRIEF.md
# Flash Page Transfer Counter with Word FIFO

This block sits between the byte-wide data cycles of a raw flash interface and a 32-bit peripheral DMA port. A down-counter is loaded with the number of bytes in the page data area and counts down by one for every byte cycle. The flash data cycles come from a separate cycle sequencer, which pulses a strobe each time a byte is taken or delivered. In the read direction the block packs flash bytes into words and queues them in a small FIFO for the DMA. In the write direction it queues words from the DMA and unpacks them into bytes for the sequencer.

A direction input selects the transfer direction: 1 means the data comes from the flash, 0 means it goes to the flash. A burst input makes the block ask for four-word DMA bursts and use single-word requests only for the tail. A start level enables the transfer, and dropping it pauses the transfer. When the final byte is moved a sticky done interrupt rises. Two status outputs tell whether data still sits in the word FIFO or in a partly packed word. A clean flag confirms that the count is zero and that nothing is left in either place.

Top module: `nand_xfer_fifo`

## Requirements
- R1: After reset there are no byte or DMA requests, the FIFO is empty, no bytes are pending, the done interrupt is low and the clean flag is high.
- R2: Asserting the count-load input stores the byte count. Each byte strobe taken while byteReq is high lowers the count by one. byteReq is high only when start is high, the count is nonzero and the FIFO can take a word (read) or holds a word (write).
- R3: In the read direction, byte k of each group of four (k = 0..3) lands in bits [8k+7:8k] of the word, so the packing is little-endian. The word enters the FIFO on the fourth byte or on the final byte of the count. Lanes not yet filled in a tail word read as zero. dmaRdData shows the oldest word, and a dmaRdPop removes it when the FIFO is not empty.
- R4: In the write direction, flashWrData shows byte lane k of the oldest FIFO word, lowest lane first. The word leaves the FIFO after its fourth byte or after the final byte of the count.
- R5: In read with burst enabled, dmaBurstReq is high while at least four words are queued and start is high.
- R6: dmaSingleReq and dmaBurstReq are never high together. Without burst, a single request is raised for any queued word (read) or free slot with words still owed (write). With burst, single requests are used only once fewer than four words remain owed.
- R7: In write with burst enabled, dmaBurstReq is high while at least four slots are free and at least four words are still owed.
- R8: doneIrq rises on the clock edge that takes the final byte. It stays high until irqClear. If both happen in the same cycle, the set wins.
- R9: While start is low, byteReq and both DMA requests stay low and the count holds. Raising start again resumes the transfer where it stopped.
- R10: fifoNotEmpty is high whenever a word is queued. bytesPending is high while a word is part-way through packing or unpacking.
- R11: xferClean is high only when the count is zero, the FIFO is empty and no bytes are pending.
- R12: A DMA word offered in the write direction while the FIFO is full is dropped, and the queued words keep their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startEn | input | 1 | Transfer enable level |
| dirRead | input | 1 | 1 = flash to DMA, 0 = DMA to flash |
| burstEn | input | 1 | Use four-word DMA bursts |
| countLoad | input | 1 | Load byte count |
| countValue | input | 16 | Byte count to load |
| irqClear | input | 1 | Clear the done interrupt |
| byteStrobe | input | 1 | Sequencer completed a byte cycle |
| byteReq | output | 1 | Block is ready for a byte cycle |
| flashRdData | input | 8 | Byte read from flash |
| flashWrData | output | 8 | Byte to write to flash |
| dmaBurstReq | output | 1 | Four-word DMA request |
| dmaSingleReq | output | 1 | One-word DMA request |
| dmaWrValid | input | 1 | DMA presents a word (write direction) |
| dmaWrData | input | 32 | Word from DMA |
| dmaRdPop | input | 1 | DMA takes a word (read direction) |
| dmaRdData | output | 32 | Oldest queued word |
| fifoNotEmpty | output | 1 | Word FIFO holds data |
| bytesPending | output | 1 | Partly packed or unpacked word |
| doneIrq | output | 1 | Sticky transfer-done interrupt |
| xferClean | output | 1 | Count zero and nothing left buffered |

## Verification
Every state change here takes exactly one register stage. A strobe, pop or push sampled at a rising edge shows up after that edge: in the count, in the FIFO occupancy, and in byteReq, the request outputs, the status flags and the interrupt. The combinational outputs also follow the start, direction and burst inputs within the same cycle. The bench drives inputs just after the falling edge and compares every output with a queue-based reference model at the next falling edge. That comparison point lies one full clock edge after the stimulus that caused the change, so both the registered and the combinational effects are due there.

// File: rtl/ntc_pkg.sv
package ntc_pkg;
  // Strobes from the control to the datapath, all valid for one clock.
  typedef struct packed {
    logic byteTake;  // a byte cycle is accepted this clock
    logic wordEnd;   // the accepted byte closes the current word
    logic fifoPush;  // write one word into the FIFO
    logic fifoPop;   // drop the oldest FIFO word
    logic clrIdx;    // restart byte lane at zero
  } ntcStrobe_t;
endpackage

// File: rtl/ntc_ctrl.sv
module ntc_ctrl
  import ntc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DEPTH = 8,
  parameter int BURST = 4,
  parameter int BPW   = 4,
  parameter int OCC_W = $clog2(DEPTH + 1),
  parameter int IDX_W = $clog2(BPW)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startEn,
  input  logic             dirRead,
  input  logic             burstEn,
  input  logic             countLoad,
  input  logic [CNT_W-1:0] countValue,
  input  logic             irqClear,
  input  logic             byteStrobe,
  input  logic             dmaWrValid,
  input  logic             dmaRdPop,
  input  logic [OCC_W-1:0] occ,
  input  logic [IDX_W-1:0] byteIdx,
  output ntcStrobe_t       stb,
  output logic             byteReq,
  output logic             dmaBurstReq,
  output logic             dmaSingleReq,
  output logic             doneIrq,
  output logic             countZero
);
  localparam logic [OCC_W-1:0] FULL_OCC  = OCC_W'(DEPTH);
  localparam logic [OCC_W-1:0] BURST_OCC = OCC_W'(BURST);
  localparam logic [CNT_W-1:0] BURST_WDS = CNT_W'(BURST);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(BPW - 1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] wordsLeft;
  logic [CNT_W-1:0] wordsFromBytes;
  logic [OCC_W-1:0] freeSlots;
  logic             fifoFull, fifoEmpty, lastByte, dmaMove;

  assign fifoFull  = (occ == FULL_OCC);
  assign fifoEmpty = (occ == '0);
  assign freeSlots = FULL_OCC - occ;
  assign countZero = (count == '0);
  assign lastByte  = (count == CNT_W'(1));

  // Words the DMA side owes for a byte count: round up to whole words.
  assign wordsFromBytes = (countValue >> IDX_W) + CNT_W'(|countValue[IDX_W-1:0]);

  assign byteReq = startEn && !countZero && (dirRead ? !fifoFull : !fifoEmpty);

  always_comb begin
    stb          = '0;
    stb.byteTake = byteStrobe && byteReq;
    stb.wordEnd  = (byteIdx == LAST_IDX) || lastByte;
    stb.clrIdx   = countLoad;
    if (dirRead) begin
      stb.fifoPush = stb.byteTake && stb.wordEnd;
      stb.fifoPop  = dmaRdPop && !fifoEmpty;
    end else begin
      stb.fifoPush = dmaWrValid && startEn && !fifoFull;
      stb.fifoPop  = stb.byteTake && stb.wordEnd;
    end
  end

  assign dmaMove = dirRead ? stb.fifoPop : stb.fifoPush;

  always_comb begin
    dmaBurstReq  = 1'b0;
    dmaSingleReq = 1'b0;
    if (startEn) begin
      if (dirRead) begin
        dmaBurstReq  = burstEn && (occ >= BURST_OCC);
        dmaSingleReq = !fifoEmpty && (!burstEn || (wordsLeft < BURST_WDS)) && !dmaBurstReq;
      end else begin
        dmaBurstReq  = burstEn && (freeSlots >= BURST_OCC) && (wordsLeft >= BURST_WDS);
        dmaSingleReq = (wordsLeft != '0) && !fifoFull &&
                       (!burstEn || (wordsLeft < BURST_WDS)) && !dmaBurstReq;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      wordsLeft <= '0;
    end else if (countLoad) begin
      count     <= countValue;
      wordsLeft <= wordsFromBytes;
    end else begin
      if (stb.byteTake) count <= count - CNT_W'(1);
      if (dmaMove && (wordsLeft != '0)) wordsLeft <= wordsLeft - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                       doneIrq <= 1'b0;
    else if (stb.byteTake && lastByte) doneIrq <= 1'b1;
    else if (irqClear)               doneIrq <= 1'b0;
  end

  // R2: every accepted byte lowers the count by exactly one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.byteTake && !countLoad) |=> (count == $past(count) - CNT_W'(1)));

  // R6: the two DMA request kinds exclude each other
  p_req_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(dmaBurstReq && dmaSingleReq));

  // R8: the interrupt holds until cleared
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doneIrq && !irqClear) |=> doneIrq);

  // R9: a stopped transfer keeps its count
  p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!startEn && !countLoad) |=> (count == $past(count)));
endmodule

// File: rtl/ntc_datapath.sv
module ntc_datapath
  import ntc_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int BPW    = DATA_W / BYTE_W,
  parameter int OCC_W  = $clog2(DEPTH + 1),
  parameter int IDX_W  = $clog2(BPW)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ntcStrobe_t        stb,
  input  logic              dirRead,
  input  logic [BYTE_W-1:0] flashRdData,
  input  logic [DATA_W-1:0] dmaWrData,
  output logic [OCC_W-1:0]  occ,
  output logic [IDX_W-1:0]  byteIdx,
  output logic [DATA_W-1:0] headWord,
  output logic [BYTE_W-1:0] flashWrData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [BYTE_W-1:0] packReg [BPW];
  logic [DATA_W-1:0] packWord, pushData;

  // Build the outgoing read word: earlier lanes from the packer,
  // the current lane from the flash bus, later lanes zero.
  for (genvar k = 0; k < BPW; k++) begin : g_lane
    assign packWord[k*BYTE_W +: BYTE_W] =
      (IDX_W'(k) <  byteIdx) ? packReg[k] :
      (IDX_W'(k) == byteIdx) ? flashRdData : '0;

    always_ff @(posedge clk) begin
      if (!rstN) packReg[k] <= '0;
      else if (stb.byteTake && dirRead && (byteIdx == IDX_W'(k))) packReg[k] <= flashRdData;
    end
  end

  assign pushData    = dirRead ? packWord : dmaWrData;
  assign headWord    = mem[rdPtr];
  assign flashWrData = headWord[byteIdx*BYTE_W +: BYTE_W];

  always_ff @(posedge clk) begin
    if (stb.fifoPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (stb.fifoPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + PTR_W'(1);
      if (stb.fifoPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + PTR_W'(1);
      case ({stb.fifoPush, stb.fifoPop})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             byteIdx <= '0;
    else if (stb.clrIdx)   byteIdx <= '0;
    else if (stb.byteTake) byteIdx <= stb.wordEnd ? '0 : byteIdx + IDX_W'(1);
  end

  // R12: the control never pushes into a full FIFO
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rstN)
    stb.fifoPush |-> ((occ != FULL_OCC) || stb.fifoPop));

  // R4: the control never pops an empty FIFO
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.fifoPop |-> (occ != '0));

  // R3: a closed word restarts the byte lane
  p_lane_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.byteTake && stb.wordEnd) |=> (byteIdx == '0));
endmodule

// File: rtl/nand_xfer_fifo.sv
module nand_xfer_fifo
  import ntc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 8,
  parameter int BURST  = 4,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEn,
  input  logic              dirRead,
  input  logic              burstEn,
  input  logic              countLoad,
  input  logic [CNT_W-1:0]  countValue,
  input  logic              irqClear,
  input  logic              byteStrobe,
  output logic              byteReq,
  input  logic [BYTE_W-1:0] flashRdData,
  output logic [BYTE_W-1:0] flashWrData,
  output logic              dmaBurstReq,
  output logic              dmaSingleReq,
  input  logic              dmaWrValid,
  input  logic [DATA_W-1:0] dmaWrData,
  input  logic              dmaRdPop,
  output logic [DATA_W-1:0] dmaRdData,
  output logic              fifoNotEmpty,
  output logic              bytesPending,
  output logic              doneIrq,
  output logic              xferClean
);
  localparam int BPW   = DATA_W / BYTE_W;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(BPW);

  ntcStrobe_t       stb;
  logic [OCC_W-1:0] occ;
  logic [IDX_W-1:0] byteIdx;
  logic             countZero;

  ntc_ctrl #(
    .CNT_W(CNT_W), .DEPTH(DEPTH), .BURST(BURST), .BPW(BPW),
    .OCC_W(OCC_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startEn(startEn), .dirRead(dirRead),
    .burstEn(burstEn), .countLoad(countLoad), .countValue(countValue),
    .irqClear(irqClear), .byteStrobe(byteStrobe), .dmaWrValid(dmaWrValid),
    .dmaRdPop(dmaRdPop), .occ(occ), .byteIdx(byteIdx), .stb(stb),
    .byteReq(byteReq), .dmaBurstReq(dmaBurstReq), .dmaSingleReq(dmaSingleReq),
    .doneIrq(doneIrq), .countZero(countZero)
  );

  ntc_datapath #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .BPW(BPW),
    .OCC_W(OCC_W), .IDX_W(IDX_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .dirRead(dirRead),
    .flashRdData(flashRdData), .dmaWrData(dmaWrData), .occ(occ),
    .byteIdx(byteIdx), .headWord(dmaRdData), .flashWrData(flashWrData)
  );

  assign fifoNotEmpty = (occ != '0);
  assign bytesPending = (byteIdx != '0);
  assign xferClean    = countZero && !fifoNotEmpty && !bytesPending;

  // R11: a clean transfer leaves no queued word behind
  p_clean_empty_r11: assert property (@(posedge clk) disable iff (!rstN)
    xferClean |-> (occ == '0));
endmodule

// File: tb/sim_nand_xfer_fifo.sv
module sim_nand_xfer_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rstN, startEn, dirRead, burstEn, countLoad, irqClear, byteStrobe;
  logic [15:0] countValue;
  logic [7:0]  flashRdData, flashWrData;
  logic        byteReq, dmaBurstReq, dmaSingleReq, dmaWrValid, dmaRdPop;
  logic [31:0] dmaWrData, dmaRdData;
  logic        fifoNotEmpty, bytesPending, doneIrq, xferClean;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_xfer_fifo u0 (
    .clk(clk), .rstN(rstN), .startEn(startEn), .dirRead(dirRead), .burstEn(burstEn),
    .countLoad(countLoad), .countValue(countValue), .irqClear(irqClear),
    .byteStrobe(byteStrobe), .byteReq(byteReq), .flashRdData(flashRdData),
    .flashWrData(flashWrData), .dmaBurstReq(dmaBurstReq), .dmaSingleReq(dmaSingleReq),
    .dmaWrValid(dmaWrValid), .dmaWrData(dmaWrData), .dmaRdPop(dmaRdPop),
    .dmaRdData(dmaRdData), .fifoNotEmpty(fifoNotEmpty), .bytesPending(bytesPending),
    .doneIrq(doneIrq), .xferClean(xferClean)
  );

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  // ---------------- reference model ----------------
  logic [31:0] q[$];
  int   mCount, mWords, mIdx;
  logic [7:0] mPack[4];
  bit   mIrq;

  function automatic bit mByteReq();
    return startEn && mCount != 0 && (dirRead ? q.size() < DEPTH : q.size() > 0);
  endfunction

  always @(posedge clk) begin : model
    bit take, last, wend, popD, pushD, xfer;
    logic [31:0] w;
    if (!rstN) begin
      q.delete(); mCount = 0; mWords = 0; mIdx = 0; mIrq = 0;
      foreach (mPack[i]) mPack[i] = 8'h00;
    end else begin
      take = byteStrobe && mByteReq();
      last = (mCount == 1);
      wend = (mIdx == 3) || last;
      w = 32'h0;
      for (int k = 0; k < 4; k++)
        if (k < mIdx) w[8*k +: 8] = mPack[k];
        else if (k == mIdx) w[8*k +: 8] = flashRdData;
      if (dirRead) begin
        popD  = dmaRdPop && q.size() > 0;
        pushD = take && wend;
        xfer  = popD;
        if (popD) void'(q.pop_front());
        if (pushD) q.push_back(w);
        if (take) mPack[mIdx] = flashRdData;
      end else begin
        pushD = dmaWrValid && startEn && q.size() < DEPTH;
        popD  = take && wend;
        xfer  = pushD;
        if (popD) void'(q.pop_front());
        if (pushD) q.push_back(dmaWrData);
      end
      if (take && last) mIrq = 1;
      else if (irqClear) mIrq = 0;
      if (countLoad) begin
        mCount = countValue; mWords = (countValue + 3) / 4; mIdx = 0;
      end else begin
        if (take) begin mCount--; mIdx = wend ? 0 : mIdx + 1; end
        if (xfer && mWords > 0) mWords--;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int occ = q.size();
    bit eBurst = 0, eSingle = 0;
    if (startEn) begin
      if (dirRead) begin
        eBurst  = burstEn && occ >= 4;
        eSingle = occ != 0 && (!burstEn || mWords < 4) && !eBurst;
      end else begin
        eBurst  = burstEn && (DEPTH - occ) >= 4 && mWords >= 4;
        eSingle = mWords != 0 && occ < DEPTH && (!burstEn || mWords < 4) && !eBurst;
      end
    end
    chk("R2 byteReq", 32'(byteReq), 32'(mByteReq()));
    chk(dirRead ? "R5 burst request" : "R7 burst request", 32'(dmaBurstReq), 32'(eBurst));
    chk("R6 single request", 32'(dmaSingleReq), 32'(eSingle));
    chk("R10 fifoNotEmpty", 32'(fifoNotEmpty), 32'(occ != 0));
    chk("R10 bytesPending", 32'(bytesPending), 32'(mIdx != 0));
    chk("R8 doneIrq", 32'(doneIrq), 32'(mIrq));
    chk("R11 xferClean", 32'(xferClean), 32'(mCount == 0 && occ == 0 && mIdx == 0));
    if (occ > 0) begin
      if (dirRead) chk("R3 dmaRdData", dmaRdData, q[0]);
      else         chk("R4 flashWrData", 32'(flashWrData), 32'(q[0][8*mIdx +: 8]));
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idleInputs();
    byteStrobe = 0; dmaRdPop = 0; dmaWrValid = 0; countLoad = 0; irqClear = 0;
  endtask

  task automatic loadCount(input int n);
    countLoad = 1; countValue = 16'(n);
    tick();
    countLoad = 0;
  endtask

  task automatic clearIrq();
    irqClear = 1; tick(); irqClear = 0;
    chk("R8 irq cleared", 32'(doneIrq), 32'h0);
  endtask

  // Random byte cycles and a DMA that answers its requests.
  task automatic runCycles(input int n, input int pStrobe);
    for (int i = 0; i < n; i++) begin
      byteStrobe  = ($urandom % 100) < pStrobe;
      flashRdData = 8'($urandom);
      dmaWrData   = $urandom;
      dmaRdPop    = dirRead && (dmaBurstReq || dmaSingleReq) && ($urandom % 3 != 0);
      dmaWrValid  = !dirRead && (dmaBurstReq || dmaSingleReq) && ($urandom % 3 != 0);
      tick();
      if (mCount == 0 && (!dirRead || q.size() == 0) && !countLoad) break;
    end
    idleInputs();
  endtask

  task automatic transfer(input bit rd, input bit bst, input int n);
    dirRead = rd; burstEn = bst; startEn = 0;
    loadCount(n);
    startEn = 1;
    runCycles(2000, 60);
    tick();
    chk("R8 irq after final byte", 32'(doneIrq), 32'h1);
    chk("R11 clean after transfer", 32'(xferClean), 32'h1);
    clearIrq();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rstN = 0; startEn = 0; dirRead = 0; burstEn = 0; countValue = '0;
    flashRdData = '0; dmaWrData = '0;
    idleInputs();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 byteReq", 32'(byteReq), 32'h0);
    chk("R1 requests", 32'({dmaBurstReq, dmaSingleReq}), 32'h0);
    chk("R1 fifoNotEmpty", 32'(fifoNotEmpty), 32'h0);
    chk("R1 doneIrq", 32'(doneIrq), 32'h0);
    chk("R1 xferClean", 32'(xferClean), 32'h1);
    rstN = 1;
    tick();

    // R3/R5: read with bursts, 22 bytes leaves a two-byte tail word
    transfer(1'b1, 1'b1, 22);
    // R4/R6: write, single requests only, 13 bytes
    transfer(1'b0, 1'b0, 13);
    // R7: write with bursts, 32 bytes
    transfer(1'b0, 1'b1, 32);
    // R6: read, single requests, 9 bytes
    transfer(1'b1, 1'b0, 9);

    // R9: pause in the middle of a read
    dirRead = 1; burstEn = 1; startEn = 0;
    loadCount(16);
    startEn = 1;
    runCycles(6, 100);
    startEn = 0;
    for (int i = 0; i < 5; i++) begin
      byteStrobe = 1; dmaRdPop = 0;
      tick();
      chk("R9 byteReq while stopped", 32'(byteReq), 32'h0);
      chk("R9 requests while stopped", 32'({dmaBurstReq, dmaSingleReq}), 32'h0);
    end
    idleInputs();
    startEn = 1;
    runCycles(2000, 60);
    tick();
    chk("R9 resumed transfer finishes", 32'(doneIrq), 32'h1);
    clearIrq();

    // R12: overfill the FIFO in the write direction
    dirRead = 0; burstEn = 0; startEn = 0;
    loadCount(40);
    startEn = 1;
    for (int i = 0; i < 12; i++) begin
      dmaWrValid = 1; dmaWrData = 32'hA0B0C000 + 32'(i);
      tick();
    end
    idleInputs();
    tick();
    chk("R12 FIFO full, no single request", 32'(dmaSingleReq), 32'h0);
    chk("R12 oldest word kept", 32'(flashWrData), 32'h00);
    runCycles(2000, 60);
    tick();
    chk("R12 overfilled transfer finishes", 32'(xferClean), 32'h1);
    clearIrq();

    // R11: leftover word makes the transfer unclean
    dirRead = 0; burstEn = 0; startEn = 0;
    loadCount(4);
    startEn = 1;
    for (int i = 0; i < 2; i++) begin
      dmaWrValid = 1; dmaWrData = 32'h11223344 + 32'(i);
      tick();
    end
    idleInputs();
    for (int i = 0; i < 4; i++) begin
      byteStrobe = 1; tick();
    end
    idleInputs();
    tick();
    chk("R11 count zero but word left", 32'(xferClean), 32'h0);
    chk("R8 irq on final byte", 32'(doneIrq), 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule